// File: doc/BRIEF.md
# Streaming Read Line Buffer

This block sits between a load pipeline and a memory bus. It serves 16-byte loads that carry a streaming hint and target memory that must not be cached. The first such load to a 64-byte line issues a single line-fill request. The line comes back as four 16-byte beats and is held in one entry of a small pool. The load that caused the fill gets its chunk as soon as the matching beat arrives.

Later loads to other chunks of the same line are answered from the entry without touching the bus. Each chunk may be read once. When all four chunks of an entry have been read, the entry frees itself. Nothing held here ever reaches a cache.

The load port carries a chunk address: address bits above bit 3. Byte alignment to 16 is therefore part of the interface itself. Only one load is in flight at a time, and only one line fill is outstanding at a time.

Top module: `stream_line_buf`

## Requirements
- R1: `ld_caddr[1:0]` selects the 16-byte chunk of the line, and `ld_caddr[ADDR_W-5:2]` is the line tag. Each load gets exactly one response, carrying the 16 bytes at that chunk address. A new load is accepted only once the previous load has been answered.
- R2: A load whose line is not held raises `fill_req_valid`, with `fill_req_line` set to the load's line tag. The request stays asserted and stable until `fill_req_ready` is seen.
- R3: A fill returns four beats, chunk 0 first through chunk 3 last. The missing load's response appears in the cycle after the beat whose index equals its chunk.
- R4: A load to a held line whose chunk has not yet been read is answered in the cycle after acceptance, and raises no fill request.
- R5: Four loads covering the four chunks of one line cause exactly one fill request.
- R6: Once all four chunks of an entry have been read, the entry is released. The next load to that line fetches the line again.
- R7: A second read of an already-read chunk of a held line fetches the line again into the same entry. This is accepted even when every entry is in use.
- R8: When every entry is in use and a load misses, `ld_ready` stays low and no request is issued until an entry is released.
- R9: At most one fill is outstanding, and `ld_ready` is low from the request handshake until the fourth beat.
- R10: After reset `ld_ready` is high and `rsp_valid` and `fill_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| ld_valid | input | 1 | load present |
| ld_ready | output | 1 | load accepted this cycle when valid |
| ld_caddr | input | ADDR_W-4 | chunk address of the load |
| rsp_valid | output | 1 | one-cycle load response |
| rsp_data | output | 128 | returned 16 bytes |
| fill_req_valid | output | 1 | line fill request |
| fill_req_ready | input | 1 | bus accepts the request |
| fill_req_line | output | ADDR_W-6 | line address of the request |
| fill_beat_valid | input | 1 | fill beat present |
| fill_beat_data | input | 128 | fill beat payload |

## Verification
The assertions take the following for granted about the bus:
- it returns exactly four beats for each accepted request;
- it sends no beat without a request outstanding;
- it holds `fill_req_ready` low except while answering a pending request.

The bench's bus model answers each request once, after a short gap, with four consecutive beats. Its data is derived only from the requested line.

Loads are presented one at a time, and each is held until it is accepted. Stall behaviour is observed by presenting a load and then withdrawing it, which the load-side contract allows.

// File: rtl/stream_line_buf.sv
module stream_line_buf #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-5:0] ld_caddr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-7:0] fill_req_line,
  input  logic              fill_beat_valid,
  input  logic [DATA_W-1:0] fill_beat_data
);
  localparam int TAG_W = ADDR_W - 6;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} state_t;
  state_t state;

  logic              ent_vld  [ENTRIES];
  logic [TAG_W-1:0]  ent_tag  [ENTRIES];
  logic [3:0]        ent_used [ENTRIES];
  logic [DATA_W-1:0] ent_data [ENTRIES][4];

  logic [IDX_W-1:0] cur_idx, hit_idx, free_idx, tgt_idx;
  logic [1:0]       cur_chunk, beat;
  logic             tag_hit, free_any, fresh, accept;

  wire [TAG_W-1:0] ld_tag   = ld_caddr[ADDR_W-5:2];
  wire [1:0]       ld_chunk = ld_caddr[1:0];

  always_comb begin
    tag_hit  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!tag_hit && ent_vld[i] && ent_tag[i] == ld_tag) begin
        tag_hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!free_any && !ent_vld[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign fresh          = tag_hit && !ent_used[hit_idx][ld_chunk];
  assign tgt_idx        = tag_hit ? hit_idx : free_idx;
  assign ld_ready       = (state == S_IDLE) && (tag_hit || free_any);
  assign accept         = ld_valid && ld_ready;
  assign fill_req_valid = (state == S_REQ);
  assign fill_req_line  = ent_tag[cur_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      cur_idx   <= '0;
      cur_chunk <= '0;
      beat      <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_vld[i]  <= 1'b0;
        ent_tag[i]  <= '0;
        ent_used[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (fresh) begin
            rsp_valid <= 1'b1;
            rsp_data  <= ent_data[hit_idx][ld_chunk];
            ent_used[hit_idx][ld_chunk] <= 1'b1;
            if (&(ent_used[hit_idx] | (4'b0001 << ld_chunk)))
              ent_vld[hit_idx] <= 1'b0;
          end else begin
            ent_vld[tgt_idx]  <= 1'b1;
            ent_tag[tgt_idx]  <= ld_tag;
            ent_used[tgt_idx] <= '0;
            cur_idx   <= tgt_idx;
            cur_chunk <= ld_chunk;
            state     <= S_REQ;
          end
        end
        S_REQ: if (fill_req_ready) begin
          beat  <= '0;
          state <= S_FILL;
        end
        S_FILL: if (fill_beat_valid) begin
          if (beat == cur_chunk) begin
            rsp_valid <= 1'b1;
            rsp_data  <= fill_beat_data;
            ent_used[cur_idx][beat] <= 1'b1;
          end
          beat <= beat + 2'd1;
          if (beat == 2'd3) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && fill_beat_valid)
      ent_data[cur_idx][beat] <= fill_beat_data;
  end
endmodule

// File: rtl/stream_line_buf_chk.sv
module stream_line_buf_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              rsp_valid,
  input logic              fill_req_valid,
  input logic              fill_req_ready,
  input logic [ADDR_W-7:0] fill_req_line,
  input logic              fill_beat_valid
);
  logic       out_busy, ld_busy;
  logic [1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_busy <= 1'b0;
      ld_busy  <= 1'b0;
      beats    <= '0;
    end else begin
      if (fill_req_valid && fill_req_ready) begin
        out_busy <= 1'b1;
        beats    <= '0;
      end else if (out_busy && fill_beat_valid) begin
        beats <= beats + 2'd1;
        if (beats == 2'd3) out_busy <= 1'b0;
      end
      if (ld_valid && ld_ready) ld_busy <= 1'b1;
      else if (rsp_valid)       ld_busy <= 1'b0;
    end
  end

  // R9
  one_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_busy |-> !fill_req_valid);
  // R9
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_busy |-> !ld_ready);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable(fill_req_line));
  // R1
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ld_busy);
  // R1
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready |-> !ld_busy || rsp_valid);
endmodule

bind stream_line_buf stream_line_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .rsp_valid(rsp_valid), .fill_req_valid(fill_req_valid),
  .fill_req_ready(fill_req_ready), .fill_req_line(fill_req_line),
  .fill_beat_valid(fill_beat_valid)
);

// File: tb/sim_stream_line_buf.sv
`timescale 1ns/1ps
module sim_stream_line_buf;
  localparam int AW = 32;

  logic           clk = 0, rst_n = 0;
  logic           ld_valid = 0, ld_ready;
  logic [AW-5:0]  ld_caddr = '0;
  logic           rsp_valid;
  logic [127:0]   rsp_data;
  logic           fill_req_valid, fill_req_ready = 0;
  logic [AW-7:0]  fill_req_line;
  logic           fill_beat_valid = 0;
  logic [127:0]   fill_beat_data = '0;

  int tests = 0, fails = 0, req_count = 0, beats_seen = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  stream_line_buf u0 (.*);

  function automatic logic [127:0] mem(input logic [AW-5:0] a);
    return {4'h1, a, 4'h2, ~a, 4'h3, a ^ 28'h5A5A5A5, 4'h4, a + 28'd7};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (fill_beat_valid) beats_seen = beats_seen + 1;

  initial begin
    forever begin
      @(negedge clk);
      if (fill_req_valid) begin
        logic [AW-7:0] line;
        line = fill_req_line;
        req_count++;
        beats_seen = 0;
        fill_req_ready = 1;
        @(negedge clk) fill_req_ready = 0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          fill_beat_valid = 1;
          fill_beat_data  = mem({line, 2'(k)});
          @(negedge clk);
        end
        fill_beat_valid = 0;
      end
    end
  end

  always @(negedge clk) if (rsp_valid) begin
    if (exp_q.size() == 0) chk(0, "R1 unexpected rsp", rsp_data, '0);
    else begin
      logic [127:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rsp_data == e, t, rsp_data, e);
    end
  end

  task automatic do_load(input logic [AW-7:0] line, input logic [1:0] ch, input bit is_hit, input string tag);
    int rc;
    rc = req_count;
    exp_q.push_back(mem({line, ch}));
    tag_q.push_back({tag, " data"});
    @(negedge clk);
    ld_valid = 1;
    ld_caddr = {line, ch};
    #1;
    while (!ld_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    ld_valid = 0;
    if (is_hit) begin
      chk(rsp_valid == 1, {tag, " hit latency"}, rsp_valid, 1);
      chk(req_count == rc, {tag, " no request"}, req_count, rc);
    end else begin
      for (int n = 0; n < 100 && !rsp_valid; n++) @(negedge clk);
      chk(beats_seen == ch + 1, {tag, " R3 beat order"}, beats_seen, ch + 1);
      chk(req_count == rc + 1, {tag, " one request"}, req_count, rc + 1);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10
    chk(ld_ready && !rsp_valid && !fill_req_valid, "R10 reset",
        {ld_ready, rsp_valid, fill_req_valid}, 3'b100);
    // R2 R3 R4 R5: one line fully read with one fetch
    do_load(26'h0A0, 2'd0, 0, "R2");
    do_load(26'h0A0, 2'd1, 1, "R4");
    do_load(26'h0A0, 2'd2, 1, "R4");
    do_load(26'h0A0, 2'd3, 1, "R4");
    chk(req_count == 1, "R5 single fetch", req_count, 1);
    // R6
    do_load(26'h0A0, 2'd0, 0, "R6 refetch after release");
    do_load(26'h0A0, 2'd2, 1, "R6");
    do_load(26'h0A0, 2'd1, 1, "R6");
    do_load(26'h0A0, 2'd3, 1, "R6");
    // R7 reread consumed chunk
    do_load(26'h0B7, 2'd2, 0, "R3");
    do_load(26'h0B7, 2'd2, 0, "R7 reread");
    do_load(26'h0B7, 2'd0, 1, "R7");
    do_load(26'h0B7, 2'd1, 1, "R7");
    do_load(26'h0B7, 2'd3, 1, "R7");
    chk(req_count == 4, "R7 count", req_count, 4);
    // R8 fill the pool
    do_load(26'h100, 2'd0, 0, "R8 fill");
    do_load(26'h200, 2'd1, 0, "R8 fill");
    do_load(26'h300, 2'd3, 0, "R8 fill");
    do_load(26'h3FF, 2'd2, 0, "R8 fill");
    @(negedge clk);
    ld_valid = 1;
    ld_caddr = {26'h155, 2'd0};
    for (int n = 0; n < 6; n++) begin
      @(negedge clk); #1;
      chk(!ld_ready && !fill_req_valid, "R8 stall", {ld_ready, fill_req_valid}, 2'b00);
    end
    ld_valid = 0;
    do_load(26'h100, 2'd0, 0, "R7 refetch with full pool");
    do_load(26'h100, 2'd1, 1, "R6");
    do_load(26'h100, 2'd2, 1, "R6");
    do_load(26'h100, 2'd3, 1, "R6");
    do_load(26'h155, 2'd0, 0, "R8 after release");
    chk(req_count == 10, "R9 total requests", req_count, 10);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all answered", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule